// File: doc/BRIEF.md
# SPI Memory Slave Serial Front End

This block sits between the pins of a serial memory slave and its command decoder. It runs on a fast system clock and oversamples the chip select, serial clock, serial data input and pause (hold) inputs through two-flop synchronisers. Edges of the serial clock are found in the system clock domain. The system clock must run at least four times faster than the serial clock.

Incoming bits are collected most significant bit first into bytes. Each completed byte goes to the decoder with a one-cycle strobe and a position number: 0 is the command byte, and the count rises from there. In the other direction, the decoder offers a response byte on `tx_byte`. The front end shifts it out on `so_data` and drives `so_oe` to say when the pin should actually be driven.

Both idle levels of the serial clock (modes 0 and 3) are accepted. A pause request from the host freezes the transfer without losing its place. A standby flag tells the rest of the chip when it is deselected and no self-timed operation is still running.

Top module: `spi_flash_front`

## Requirements
- R1: A falling chip select (active low) starts a frame and clears the bit counter and the byte position. A rising chip select ends the frame, and any partly received byte is dropped without a strobe.
- R2: Data input is sampled on serial clock rising edges, most significant bit first. After every eighth bit, `byte_vld` is high for exactly one system cycle, with the byte on `byte_data` and its position on `byte_idx`. The position is 0 for the first byte, goes up by one per byte, and stays at 2^IDX_W-1 once it gets there.
- R3: Frames work the same whether the serial clock idles low (mode 0) or high (mode 3) when chip select falls.
- R4: `so_data` changes only after serial clock falling edges. It holds the MSB of `tx_byte` from the start of the frame. At the first falling edge after each completed byte it reloads from `tx_byte`. Each other falling edge moves it to the next lower bit. In every byte period the host therefore reads `tx_byte` MSB first.
- R5: While deselected, `so_oe` is low and serial clock or data activity produces no strobe.
- R6: While paused, `so_oe` is low, serial clock edges and data are ignored, and the partly received byte and the position are kept. Releasing the pause resumes the byte where it stopped.
- R7: A pause requested while the serial clock is high takes effect only once the serial clock is low. Until then, `so_oe` stays high.
- R8: `standby` is high only when the block is deselected and `busy` is low. If chip select rises during `busy`, `standby` rises only after `busy` clears. On reset, `standby`, `so_oe` and `byte_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_in | input | 1 | Chip select pin, active low |
| sck_in | input | 1 | Serial clock pin |
| si_in | input | 1 | Serial data input pin |
| hold_n_in | input | 1 | Pause request pin, active low |
| busy | input | 1 | Self-timed operation in progress |
| tx_byte | input | 8 | Response byte to be shifted out |
| so_data | output | 1 | Serial data output value |
| so_oe | output | 1 | Serial data output enable |
| byte_vld | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_idx | output | IDX_W | Position of the received byte in the frame |
| standby | output | 1 | Deselected and idle |

## Verification
A table of frames is run in both clock modes. The command and payload bytes have alternating, sparse and dense bit patterns, so a bit-order or shift-direction error shows up at once. In every frame the byte read back on the output must equal the offered response byte, which separates a correct falling-edge reload from an off-by-one shift. Pauses are issued with the clock low and with the clock high, which separates an immediate entry from a deferred one. A frame longer than the position counter can hold shows saturation, and a frame cut off mid-byte shows that the partial byte is dropped.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_in,
  input  logic             sck_in,
  input  logic             si_in,
  input  logic             hold_n_in,
  input  logic             busy,
  input  logic [7:0]       tx_byte,
  output logic             so_data,
  output logic             so_oe,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic             standby
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [1:0] cs_q, sck_q, si_q, hold_q;
  logic       cs_d, sck_d, held;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic [IDX_W-1:0] idx;

  wire cs_s   = cs_q[1];
  wire sck_s  = sck_q[1];
  wire si_s   = si_q[1];
  wire hold_s = hold_q[1];

  wire sel    = ~cs_s;
  wire start  = sel & cs_d;
  wire held_n = sel & ~hold_s & (held | ~sck_s);
  wire run    = sel & ~held;
  wire rise   = run & sck_s & ~sck_d;
  wire fall   = run & ~sck_s & sck_d;

  assign so_data = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 2'b11;
      sck_q     <= 2'b00;
      si_q      <= 2'b00;
      hold_q    <= 2'b11;
      cs_d      <= 1'b1;
      sck_d     <= 1'b0;
      held      <= 1'b0;
      so_oe     <= 1'b0;
      standby   <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_idx  <= '0;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      idx       <= '0;
    end else begin
      cs_q     <= {cs_q[0], cs_n_in};
      sck_q    <= {sck_q[0], sck_in};
      si_q     <= {si_q[0], si_in};
      hold_q   <= {hold_q[0], hold_n_in};
      cs_d     <= cs_s;
      sck_d    <= sck_s;
      held     <= held_n;
      so_oe    <= sel & ~held_n;
      standby  <= cs_s & ~busy;
      byte_vld <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (start) begin
        bit_cnt <= '0;
        idx     <= '0;
        tx_sr   <= tx_byte;
      end else begin
        if (rise) begin
          rx_sr   <= {rx_sr[5:0], si_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_vld  <= 1'b1;
            byte_data <= {rx_sr, si_s};
            byte_idx  <= idx;
            if (idx != IDX_MAX) idx <= idx + 1'b1;
          end
        end
        if (fall) tx_sr <= (bit_cnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
      end
    end
  end

  // R1
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_s) |=> (bit_cnt == 3'd0));
  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
  // R5
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);
  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && sel) |=> $stable(bit_cnt));
  // R6
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !byte_vld);
  // R8
  busy_blocks_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !standby);
endmodule

// File: tb/tb_spi_flash_front.sv
module tb_spi_flash_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n_in = 1'b1, sck_in = 1'b0, si_in = 1'b0, hold_n_in = 1'b1, busy = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic so_data, so_oe, byte_vld, standby;
  logic [7:0] byte_data;
  logic [3:0] byte_idx;

  spi_flash_front #(.IDX_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sck_in(sck_in), .si_in(si_in),
    .hold_n_in(hold_n_in), .busy(busy), .tx_byte(tx_byte), .so_data(so_data),
    .so_oe(so_oe), .byte_vld(byte_vld), .byte_data(byte_data), .byte_idx(byte_idx),
    .standby(standby));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, nrx = 0;
  logic [7:0] rx_d [0:63];
  logic [3:0] rx_i [0:63];

  always @(negedge clk) if (byte_vld && nrx < 64) begin
    rx_d[nrx] = byte_data;
    rx_i[nrx] = byte_idx;
    nrx++;
  end

  // mode, cmd, b1, b2, tx
  localparam logic [32:0] VEC [0:3] = '{
    {1'b0, 8'h9F, 8'hA5, 8'h01, 8'hC3},
    {1'b1, 8'h03, 8'h5A, 8'hFF, 8'h81},
    {1'b0, 8'h02, 8'h00, 8'h7E, 8'h6D},
    {1'b1, 8'hD8, 8'h80, 8'h3C, 8'h12}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_frame(input bit mode3);
    sck_in = mode3;
    wclk(4);
    cs_n_in = 1'b0;
    wclk(4);
  endtask

  task automatic end_frame(input bit mode3);
    if (!mode3) sck_in = 1'b0;
    wclk(4);
    cs_n_in = 1'b1;
    wclk(4);
  endtask

  task automatic sbit(input bit b, output bit so);
    sck_in = 1'b0;
    si_in = b;
    wclk(4);
    so = so_data;
    sck_in = 1'b1;
    wclk(4);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic [7:0] so);
    for (int i = 7; i >= 0; i--) begin
      bit o;
      sbit(b[i], o);
      so[i] = o;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] so;
    bit o;
    int base;
    wclk(3);
    // R8 reset state
    chk(!so_oe && !byte_vld && !standby, "R8 reset", {so_oe, byte_vld, standby}, 0);
    rst_n = 1'b1;
    wclk(4);
    chk(standby == 1'b1, "R8 idle standby", standby, 1);

    // R2 R3 R4 vector table, both modes
    for (int v = 0; v < 4; v++) begin
      logic [7:0] bytes [0:2];
      bit m3;
      {m3, bytes[0], bytes[1], bytes[2], tx_byte} = VEC[v];
      base = nrx;
      begin_frame(m3);
      for (int k = 0; k < 3; k++) begin
        sbyte(bytes[k], so);
        chk(so == tx_byte, "R4 so byte", so, tx_byte);
      end
      end_frame(m3);
      chk(nrx == base + 3, "R3 strobe count", nrx - base, 3);
      for (int k = 0; k < 3; k++) begin
        chk(rx_d[base+k] == bytes[k], "R2 data", rx_d[base+k], bytes[k]);
        chk(rx_i[base+k] == 4'(k), "R2 index", rx_i[base+k], k);
      end
    end

    // R5 deselected: activity ignored
    base = nrx;
    for (int i = 0; i < 16; i++) begin
      sck_in = ~sck_in; si_in = ~si_in; wclk(3);
      chk(so_oe == 1'b0, "R5 so_oe off", so_oe, 0);
    end
    sck_in = 1'b0;
    wclk(4);
    chk(nrx == base, "R5 no strobe", nrx - base, 0);

    // R1 partial byte discarded, counters reset
    base = nrx;
    begin_frame(1'b0);
    for (int i = 0; i < 5; i++) sbit(1'b1, o);
    end_frame(1'b0);
    begin_frame(1'b0);
    sbyte(8'hA5, so);
    end_frame(1'b0);
    chk(nrx == base + 1, "R1 strobe count", nrx - base, 1);
    chk(rx_d[base] == 8'hA5 && rx_i[base] == 4'd0, "R1 fresh byte", {rx_i[base], rx_d[base]}, 12'h0A5);

    // R6 pause with clock low
    base = nrx;
    begin_frame(1'b0);
    sbyte(8'h9F, so);
    sbit(1'b1, o); sbit(1'b0, o); sbit(1'b1, o);
    sck_in = 1'b0; wclk(4);
    hold_n_in = 1'b0; wclk(4);
    chk(so_oe == 1'b0, "R6 so_oe off", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      sck_in = 1'b1; si_in = 1'b0; wclk(4);
      sck_in = 1'b0; wclk(4);
    end
    chk(nrx == base + 1, "R6 edges ignored", nrx - base, 1);
    hold_n_in = 1'b1; wclk(4);
    chk(so_oe == 1'b1, "R6 resume oe", so_oe, 1);
    sbit(1'b1, o); sbit(1'b1, o); sbit(1'b0, o); sbit(1'b0, o); sbit(1'b1, o);
    end_frame(1'b0);
    chk(nrx == base + 2, "R6 count", nrx - base, 2);
    chk(rx_d[base+1] == 8'hB9 && rx_i[base+1] == 4'd1, "R6 resumed byte",
        {rx_i[base+1], rx_d[base+1]}, 12'h1B9);

    // R7 pause requested with clock high is deferred
    base = nrx;
    begin_frame(1'b1);
    sbyte(8'h05, so);
    hold_n_in = 1'b0; wclk(6);
    chk(so_oe == 1'b1, "R7 deferred", so_oe, 1);
    sck_in = 1'b0; wclk(4);
    chk(so_oe == 1'b0, "R7 entered", so_oe, 0);
    hold_n_in = 1'b1; wclk(4);
    sbyte(8'h3C, so);
    end_frame(1'b1);
    chk(nrx == base + 2 && rx_d[base+1] == 8'h3C && rx_i[base+1] == 4'd1, "R7 bytes",
        rx_d[base+1], 8'h3C);

    // R2 position saturates
    base = nrx;
    begin_frame(1'b0);
    for (int i = 0; i < 17; i++) sbyte(8'(i + 8'h40), so);
    end_frame(1'b0);
    chk(nrx == base + 17, "R2 long count", nrx - base, 17);
    chk(rx_i[base+15] == 4'd15, "R2 index max", rx_i[base+15], 15);
    chk(rx_i[base+16] == 4'd15 && rx_d[base+16] == 8'h50, "R2 saturate",
        {rx_i[base+16], rx_d[base+16]}, 12'hF50);

    // R8 standby deferred while busy
    begin_frame(1'b0);
    sbyte(8'h06, so);
    chk(standby == 1'b0, "R8 selected", standby, 0);
    busy = 1'b1;
    end_frame(1'b0);
    wclk(4);
    chk(standby == 1'b0, "R8 busy hold-off", standby, 0);
    busy = 1'b0; wclk(2);
    chk(standby == 1'b1, "R8 standby after busy", standby, 1);

    finish_run();
  end
endmodule